// File: doc/BRIEF.md
# Windowed Binary-Search Amplitude Controller

This block regulates the swing of a crystal oscillator by steering an 8-bit bias-current code. It runs on the oscillator's own clock. An external window detector provides two flags. `up_i` means the amplitude is below the target window. `down_i` means it is above the window.

A high-Q crystal settles slowly. The controller therefore acts only once per settle interval, and the length of that interval is a parameter given in clock cycles. At each interval end, the block applies one step of a binary search and then halves the step for the next decision. The search stops early with the code frozen as soon as neither flag is set. It also stops after the smallest step has been applied.

A start-up boost enable is driven for the first interval only, to speed up the oscillator's build-up.

Top module: `amp_ctrl`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `bias_code_o` is 128, `boost_en_o` is 1 and `done_o` is 0.
- R2: `bias_code_o` changes only on a settle expiry edge. The expiry edges are the rising clock edges numbered k·SETTLE_CYCLES, counting the first edge after reset release as edge 1.
- R3: At an expiry with the synchronized up flag alone high, the code rises by the current step. The first step is 64, so the first such update gives 192 from reset.
- R4: At an expiry with the synchronized down flag alone high, the code falls by the current step. From 192, the second step gives 160.
- R5: Each raise or lower halves the step, which runs 64, 32, 16, 8, 4, 2, 1. Once the step of 1 has been applied, `done_o` goes to 1 and the code is frozen until reset.
- R6: At an expiry with both flags low, `done_o` goes to 1 and the code stays frozen from then on, whatever the flags do.
- R7: At an expiry with both flags high, the code holds, the step does not halve and `done_o` stays 0.
- R8: Arithmetic saturates within 0..255 and never wraps. Raising at every step ends at 255, and lowering at every step ends at 1.
- R9: Each flag passes through a two-flop synchronizer. A flag level that changes after clock edge k·SETTLE_CYCLES−2 does not affect the update at edge k·SETTLE_CYCLES.
- R10: `boost_en_o` is 1 from reset until the first expiry edge, and it is 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-derived clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_i | input | 1 | Amplitude below window (asynchronous) |
| down_i | input | 1 | Amplitude above window (asynchronous) |
| bias_code_o | output | 8 | Bias-current code |
| boost_en_o | output | 1 | Start-up current boost enable |
| done_o | output | 1 | Search finished; code frozen |

## Verification
The hardest case to reach from the ports is a flag change that lands inside the synchronizer latency just before an expiry edge. The change must be invisible to that update and take effect only at the following one. A directed sequence counts edges from reset release and flips the flags exactly one edge late. Random flag mixes over many resets, weighted to include the invalid both-high state, then walk the search through early window stops, full-depth termination and holds with unchanged step. Two directed runs raise at every step and lower at every step to reach the code extremes.

// File: rtl/amp_ctrl_pkg.sv
package amp_ctrl_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD  = 2'd0,
    DEC_RAISE = 2'd1,
    DEC_LOWER = 2'd2,
    DEC_INWIN = 2'd3
  } dec_e;

  function automatic dec_e decide(input logic up, input logic dn);
    unique case ({up, dn})
      2'b10:   return DEC_RAISE;
      2'b01:   return DEC_LOWER;
      2'b00:   return DEC_INWIN;
      default: return DEC_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/amp_sync.sv
module amp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= d_i;
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/amp_settle_timer.sv
module amp_settle_timer #(
  parameter int SETTLE_CYCLES = 96000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R2
  cnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/amp_search_core.sv
module amp_search_core
  import amp_ctrl_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CODE_W-1:0] code_o,
  output logic              boost_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] STEP_INIT = CODE_W'(1) << (CODE_W - 2);
  localparam logic [CODE_W-1:0] CODE_MAX  = '1;

  logic [CODE_W-1:0] code_q, step_q;
  logic              done_q, boost_q;
  logic [CODE_W:0]   sum, diff;
  logic [CODE_W-1:0] code_up, code_dn;
  logic              last_step, act;
  dec_e              dec;

  assign sum       = {1'b0, code_q} + {1'b0, step_q};
  assign diff      = {1'b0, code_q} - {1'b0, step_q};
  assign code_up   = sum[CODE_W]  ? CODE_MAX : sum[CODE_W-1:0];
  assign code_dn   = diff[CODE_W] ? '0       : diff[CODE_W-1:0];
  assign last_step = (step_q == CODE_W'(1));
  assign act       = tick_i && !done_q;
  assign dec       = decide(up_i, dn_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      code_q <= CODE_MID;
      step_q <= STEP_INIT;
      done_q <= 1'b0;
    end else if (act) begin
      unique case (dec)
        DEC_RAISE: begin
          code_q <= code_up;
          step_q <= step_q >> 1;
          done_q <= last_step;
        end
        DEC_LOWER: begin
          code_q <= code_dn;
          step_q <= step_q >> 1;
          done_q <= last_step;
        end
        DEC_INWIN: done_q <= 1'b1;
        default:   ;
      endcase
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     boost_q <= 1'b1;
    else if (tick_i) boost_q <= 1'b0;

  assign code_o  = code_q;
  assign boost_o = boost_q;
  assign done_o  = done_q;

  // R5
  step_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> $onehot0(step_q) && (step_q != '0));

  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q && $stable(code_q));

  // R7
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && up_i && dn_i) |=> $stable(code_q) && $stable(step_q) && $stable(done_q));

  // R10
  boost_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boost_q |=> !boost_q);
endmodule

// File: rtl/amp_ctrl.sv
module amp_ctrl #(
  parameter int CODE_W        = 8,
  parameter int SETTLE_CYCLES = 96000,  // ~3 ms at 32 MHz
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              down_i,
  output logic [CODE_W-1:0] bias_code_o,
  output logic              boost_en_o,
  output logic              done_o
);
  logic [1:0] flags_s;
  logic       tick;

  amp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({up_i, down_i}),
    .q_o   (flags_s)
  );

  amp_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  amp_search_core #(.CODE_W(CODE_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .up_i   (flags_s[1]),
    .dn_i   (flags_s[0]),
    .code_o (bias_code_o),
    .boost_o(boost_en_o),
    .done_o (done_o)
  );

  // R2
  code_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bias_code_o != $past(bias_code_o)) |-> $past(tick));

  // R10
  boost_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(boost_en_o) |-> $past(tick));
endmodule

// File: tb/amp_ctrl_test.sv
`timescale 1ns/1ps
module amp_ctrl_test;
  localparam int S = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       up_i = 1'b0;
  logic       down_i = 1'b0;
  logic [7:0] bias_code_o;
  logic       boost_en_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int exp_code, exp_step;
  bit exp_done, exp_boost;

  always #2.5 clk_i = ~clk_i;

  amp_ctrl #(.CODE_W(8), .SETTLE_CYCLES(S), .SYNC_STAGES(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(up_i), .down_i(down_i),
    .bias_code_o(bias_code_o), .boost_en_o(boost_en_o), .done_o(done_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step(bit u, bit d);
    exp_boost = 0;
    if (exp_done) return;
    if (u && !d) begin
      exp_code = (exp_code + exp_step > 255) ? 255 : exp_code + exp_step;
      if (exp_step == 1) exp_done = 1; else exp_step = exp_step / 2;
    end else if (d && !u) begin
      exp_code = (exp_code - exp_step < 0) ? 0 : exp_code - exp_step;
      if (exp_step == 1) exp_done = 1; else exp_step = exp_step / 2;
    end else if (!u && !d) begin
      exp_done = 1;
    end
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; up_i = 0; down_i = 0;
    #1;
    // R1 during reset
    chk("R1 code in reset", bias_code_o, 128);
    chk("R1 boost in reset", boost_en_o, 1);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    exp_code = 128; exp_step = 64; exp_done = 0; exp_boost = 1;
    chk("R1 done after reset", done_o, 0);
  endtask

  // called just after a reset release or an expiry edge
  task automatic run_interval(bit u, bit d);
    up_i = u; down_i = d;
    repeat (S - 1) @(posedge clk_i);
    #1;
    chk("R2 code stable before expiry", bias_code_o, exp_code);
    chk("R10 boost before expiry", boost_en_o, exp_boost);
    @(posedge clk_i);
    #1;
    model_step(u, d);
    chk("R3/R4 code after expiry", bias_code_o, exp_code);
    chk("R5/R6 done after expiry", done_o, exp_done);
    chk("R10 boost after expiry", boost_en_o, exp_boost);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));

    // R1, R3, R4: 128 -> 192 -> 160, then window -> frozen (R6)
    do_reset();
    chk("R1 code after release", bias_code_o, 128);
    run_interval(1, 0);
    chk("R3 first raise", bias_code_o, 192);
    run_interval(0, 1);
    chk("R4 halved lower", bias_code_o, 160);
    run_interval(0, 0);
    chk("R6 window done", done_o, 1);
    run_interval(1, 0);
    chk("R6 frozen after window", bias_code_o, 160);

    // R7: both high holds, step kept
    do_reset();
    run_interval(1, 1);
    chk("R7 both high code", bias_code_o, 128);
    chk("R7 both high done", done_o, 0);
    run_interval(1, 0);
    chk("R7 step not advanced", bias_code_o, 192);

    // R8 and R5: all up to 255, all down to 1
    do_reset();
    for (int i = 0; i < 7; i++) run_interval(1, 0);
    chk("R8 all raise", bias_code_o, 255);
    chk("R5 done after last step", done_o, 1);
    run_interval(1, 0);
    chk("R5 frozen after last step", bias_code_o, 255);
    do_reset();
    for (int i = 0; i < 7; i++) run_interval(0, 1);
    chk("R8 all lower", bias_code_o, 1);
    chk("R5 done after last step", done_o, 1);

    // R9: change after edge S-2 is not seen at edge S
    do_reset();
    up_i = 1; down_i = 0;
    repeat (S - 2) @(posedge clk_i);
    #1;
    up_i = 0; down_i = 1;
    repeat (2) @(posedge clk_i);
    #1;
    chk("R9 late change ignored", bias_code_o, 192);
    exp_code = 192; exp_step = 32; exp_boost = 0;
    run_interval(0, 1);
    chk("R9 change seen next expiry", bias_code_o, 160);

    // random mixes
    for (int run = 0; run < 40; run++) begin
      do_reset();
      for (int k = 0; k < 9; k++) begin
        int r;
        r = $urandom_range(0, 11);
        if (r == 0)      run_interval(1, 1);
        else if (r == 1) run_interval(0, 0);
        else if (r < 7)  run_interval(1, 0);
        else             run_interval(0, 1);
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule